// File: doc/BRIEF.md
# Strobe-Handshake FIFO Buffer (64 x 5)

This block is a first-in first-out buffer of 64 five-bit words. It keeps its words in a dual-port memory with separate write and read pointers, so a write and a read can be in progress at the same time. It does not use a read/write-enable interface. A writer raises and lowers a push strobe and watches an input-ready flag. A reader raises and lowers a pop strobe and watches an output-ready flag. Both strobes may come from logic that is not timed to the block's clock. Each strobe passes through a two-stage synchronizer and an edge detector on the single system clock, so the whole block is synchronous.

A write has two halves. The rising edge of the push strobe stores the word and drops input ready. The falling edge commits the word and raises input ready again if a slot is still free. A read also has two halves. The rising edge of the pop strobe drops output ready. The falling edge retires the word, and one clock later the next word, if there is one, is presented. A word written into an empty buffer reaches the outputs one clock after its write commits. In the same way, a full buffer raises input ready one clock after a read frees a slot.

The data outputs have an enable. When the enable is low, the outputs are reported as high impedance through a separate flag and the data lines are driven to zero.

Top module: `hsf_fifo`

## Requirements
- R1: After reset, in_ready is 1, out_ready is 0, q_data is all zeros and q_hiz follows oe.
- R2: A rising edge of shift_in while in_ready is 1 stores din and drops in_ready. The falling edge that follows commits the word and raises in_ready again when fewer than 64 words are held.
- R3: When a word is committed to an empty buffer, out_ready stays 0 in the clock in which the commit takes effect and rises one clock later, with that word on q_data.
- R4: A rising edge of shift_out while out_ready is 1 drops out_ready. The falling edge that follows advances the read pointer, and the next held word is then presented with out_ready 1.
- R5: Words leave in the order they were written, with their values unchanged.
- R6: When the last word has been read, out_ready stays 0 and q_data keeps showing that last word.
- R7: With 64 words held, in_ready stays 0. A shift_in strobe in this state stores nothing and leaves the state unchanged.
- R8: When a read frees a slot in a full buffer, in_ready stays 0 in the clock in which the read commits and rises one clock later.
- R9: A shift_out strobe while out_ready is 0 and the buffer is empty is ignored: q_data and out_ready do not change, and the next word written is read normally.
- R10: With oe at 0, q_hiz is 1 and q_data is all zeros. oe does not affect the stored words, the flags or the word shown once oe returns to 1.
- R11: A push and a pop whose strobes overlap are both carried out. The occupancy stays the same, and the next word is presented after the read commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low master reset |
| shift_in | input | 1 | Push strobe; the rising edge stores, the falling edge commits |
| din | input | 5 | Word to be written |
| shift_out | input | 1 | Pop strobe; the rising edge claims, the falling edge retires |
| oe | input | 1 | Output enable for the data lines |
| in_ready | output | 1 | Ready to accept a push |
| out_ready | output | 1 | A valid word is on q_data |
| q_data | output | 5 | Presented word; zero while q_hiz is 1 |
| q_hiz | output | 1 | Data outputs are in the high-impedance state |

## Verification
The bench measures the one-clock fall-through from an empty buffer and the one-clock recovery of in_ready from a full buffer, counting every synchronizer stage. A design that presented the word early, or that never presented it, fails the R3 or R8 check. It fills all 64 slots and pushes once more. A design that wrapped its write pointer into unread data returns a wrong word or a 65th word when the buffer is drained. It also checks that the last word stays on q_data after the buffer runs empty, that a pop strobe on an empty buffer changes nothing, and that overlapped push and pop strobes keep the occupancy correct. A design that dropped one half of the overlapped pair would lose the new word or show a stale one.

// File: rtl/hsf_pkg.sv
package hsf_pkg;
  // next index of a circular pointer over a storage of `depth` slots
  function automatic int unsigned wrap_inc(int unsigned idx, int unsigned depth);
    if (idx + 1 >= depth) return 0;
    return idx + 1;
  endfunction

  // occupancy after one clock with a write commit and/or a read commit
  function automatic int unsigned occ_step(int unsigned occ, logic up, logic down);
    int unsigned r;
    r = occ;
    if (up)   r = r + 1;
    if (down) r = r - 1;
    return r;
  endfunction
endpackage

// File: rtl/hsf_strobe_sync.sv
module hsf_strobe_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe_raw,
  output logic rise,
  output logic fall
);
  // sh[STAGES-1] is the synchronized level, sh[STAGES] its previous value
  logic [STAGES:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[STAGES-1:0], strobe_raw};
  end

  assign rise = sh[STAGES-1] & ~sh[STAGES];
  assign fall = ~sh[STAGES-1] & sh[STAGES];
endmodule

// File: rtl/hsf_dpram.sv
module hsf_dpram #(
  parameter int W     = 5,
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/hsf_wr_ctrl.sv
module hsf_wr_ctrl #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          si_rise,
  input  logic          si_fall,
  input  logic [CW-1:0] occ,
  input  logic [CW-1:0] occ_nxt,
  output logic          wr_accept,
  output logic          wr_commit,
  output logic [AW-1:0] wptr,
  output logic          in_ready
);
  logic busy;

  assign wr_accept = si_rise & in_ready;
  assign wr_commit = si_fall & busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      wptr     <= '0;
      in_ready <= 1'b1;
    end else if (wr_accept) begin
      busy     <= 1'b1;
      in_ready <= 1'b0;
    end else if (wr_commit) begin
      busy     <= 1'b0;
      wptr     <= AW'(hsf_pkg::wrap_inc(32'(wptr), DEPTH));
      in_ready <= (occ_nxt < CW'(DEPTH));
    end else if (!in_ready && !busy && occ < CW'(DEPTH)) begin
      in_ready <= 1'b1;   // recovery from full, one clock after the slot frees
    end
  end

  // R2: an accepted push always drops in_ready
  p_inrdy_drop_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_accept |=> !in_ready);
  // R7: a commit never pushes occupancy past capacity
  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |-> occ < CW'(DEPTH));
endmodule

// File: rtl/hsf_rd_ctrl.sv
module hsf_rd_ctrl #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          so_rise,
  input  logic          so_fall,
  input  logic [CW-1:0] occ,
  output logic          rd_accept,
  output logic          rd_commit,
  output logic          present,
  output logic [AW-1:0] rptr,
  output logic          out_ready
);
  logic busy;

  assign rd_accept = so_rise & out_ready;
  assign rd_commit = so_fall & busy;
  assign present   = !out_ready && !busy && (occ != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy      <= 1'b0;
      rptr      <= '0;
      out_ready <= 1'b0;
    end else if (rd_accept) begin
      busy      <= 1'b1;
      out_ready <= 1'b0;
    end else if (rd_commit) begin
      busy      <= 1'b0;
      rptr      <= AW'(hsf_pkg::wrap_inc(32'(rptr), DEPTH));
    end else if (present) begin
      out_ready <= 1'b1;
    end
  end

  // R4: a claimed read always drops out_ready
  p_ordy_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_accept |=> !out_ready);
  // R9: a read never retires a word from an empty buffer
  p_no_underflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rd_commit |-> occ != '0);
endmodule

// File: rtl/hsf_fifo.sv
module hsf_fifo #(
  parameter int W       = 5,
  parameter int DEPTH   = 64,
  parameter int SYNC_FF = 2,
  localparam int AW     = $clog2(DEPTH),
  localparam int CW     = $clog2(DEPTH + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         shift_in,
  input  logic [W-1:0] din,
  input  logic         shift_out,
  input  logic         oe,
  output logic         in_ready,
  output logic         out_ready,
  output logic [W-1:0] q_data,
  output logic         q_hiz
);
  // named internal events
  logic          si_rise, si_fall, so_rise, so_fall;
  logic          wr_accept, wr_commit, rd_accept, rd_commit, present;
  logic [AW-1:0] wptr, rptr;
  logic [CW-1:0] occ, occ_nxt;
  logic [W-1:0]  ram_q, q_reg;

  hsf_strobe_sync #(.STAGES(SYNC_FF)) u_si_sync (
    .clk(clk), .rst_n(rst_n), .strobe_raw(shift_in), .rise(si_rise), .fall(si_fall));

  hsf_strobe_sync #(.STAGES(SYNC_FF)) u_so_sync (
    .clk(clk), .rst_n(rst_n), .strobe_raw(shift_out), .rise(so_rise), .fall(so_fall));

  assign occ_nxt = CW'(hsf_pkg::occ_step(32'(occ), wr_commit, rd_commit));

  always_ff @(posedge clk) begin
    if (!rst_n) occ <= '0;
    else        occ <= occ_nxt;
  end

  hsf_wr_ctrl #(.DEPTH(DEPTH)) u_wr (
    .clk(clk), .rst_n(rst_n), .si_rise(si_rise), .si_fall(si_fall),
    .occ(occ), .occ_nxt(occ_nxt), .wr_accept(wr_accept), .wr_commit(wr_commit),
    .wptr(wptr), .in_ready(in_ready));

  hsf_rd_ctrl #(.DEPTH(DEPTH)) u_rd (
    .clk(clk), .rst_n(rst_n), .so_rise(so_rise), .so_fall(so_fall), .occ(occ),
    .rd_accept(rd_accept), .rd_commit(rd_commit), .present(present),
    .rptr(rptr), .out_ready(out_ready));

  hsf_dpram #(.W(W), .DEPTH(DEPTH)) u_ram (
    .clk(clk), .we(wr_accept), .waddr(wptr), .wdata(din),
    .raddr(rptr), .rdata(ram_q));

  // output register: only loads when a word is presented, so it holds the last one
  always_ff @(posedge clk) begin
    if (!rst_n)       q_reg <= '0;
    else if (present) q_reg <= ram_q;
  end

  assign q_hiz  = ~oe;
  assign q_data = oe ? q_reg : '0;

  // R3: a commit into an empty buffer shows the word two sampled clocks later
  p_fallthru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && occ == '0) |-> ##2 out_ready);
  // R6: with nothing held and nothing shown, the output register holds still
  p_last_word_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && occ == '0) |=> $stable(q_reg));
  // R11: overlapped commits leave occupancy unchanged
  p_overlap_occ_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_commit && rd_commit) |=> $stable(occ));
endmodule

// File: tb/hsf_fifo_tb.sv
`timescale 1ns/1ps
module hsf_fifo_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       shift_in = 1'b0;
  logic       shift_out = 1'b0;
  logic       oe = 1'b1;
  logic [4:0] din = '0;
  logic       in_ready, out_ready, q_hiz;
  logic [4:0] q_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  hsf_fifo u_dut (
    .clk(clk), .rst_n(rst_n), .shift_in(shift_in), .din(din),
    .shift_out(shift_out), .oe(oe), .in_ready(in_ready),
    .out_ready(out_ready), .q_data(q_data), .q_hiz(q_hiz));

  // vector table: bit 5 = op (0 push, 1 pop), bits 4:0 = data written / expected
  localparam int NV = 12;
  localparam logic [5:0] VEC [NV] = '{
    6'h01, 6'h02, 6'h03, 6'h21, 6'h04, 6'h22,
    6'h23, 6'h24, 6'h1F, 6'h00, 6'h3F, 6'h20 };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic push(input logic [4:0] d);
    @(negedge clk);
    din = d; shift_in = 1'b1;
    idle(4);
    check(in_ready == 1'b0, "R2 in_ready low while push strobe high", in_ready, 0);
    shift_in = 1'b0;
    idle(4);
  endtask

  task automatic pop(output logic [4:0] d);
    int t;
    t = 0;
    while (!out_ready && t < 20) begin @(negedge clk); t++; end
    d = q_data;
    shift_out = 1'b1;
    idle(4);
    check(out_ready == 1'b0, "R4 out_ready low while pop strobe high", out_ready, 0);
    shift_out = 1'b0;
    idle(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    logic [4:0] got;
    idle(3);
    // R1 reset state
    check(in_ready == 1'b1, "R1 in_ready", in_ready, 1);
    check(out_ready == 1'b0, "R1 out_ready", out_ready, 0);
    check(q_data == 5'd0 && q_hiz == 1'b0, "R1 q_data", q_data, 0);
    rst_n = 1'b1;
    idle(2);

    // R3 exact fall-through timing from empty
    @(negedge clk); din = 5'd9; shift_in = 1'b1;
    idle(4);
    shift_in = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_ready == 1'b0, "R3 not yet presented", out_ready, 0);
    @(posedge clk); @(negedge clk);
    check(out_ready == 1'b1, "R3 presented one clock later", out_ready, 1);
    check(q_data == 5'd9, "R3 fall-through word", q_data, 9);
    check(in_ready == 1'b1, "R2 in_ready back after commit", in_ready, 1);

    // R6 last word held when empty
    pop(got);
    check(got == 5'd9, "R6 read word", got, 9);
    idle(5);
    check(out_ready == 1'b0, "R6 out_ready low when empty", out_ready, 0);
    check(q_data == 5'd9, "R6 last word held", q_data, 9);

    // R9 pop strobe on empty buffer ignored
    @(negedge clk); shift_out = 1'b1; idle(4); shift_out = 1'b0; idle(6);
    check(out_ready == 1'b0, "R9 out_ready unchanged", out_ready, 0);
    check(q_data == 5'd9, "R9 q_data unchanged", q_data, 9);
    push(5'd12);
    pop(got);
    check(got == 5'd12, "R9 next word read normally", got, 12);

    // R5 table-driven order check
    for (int v = 0; v < NV; v++) begin
      if (VEC[v][5] == 1'b0) push(VEC[v][4:0]);
      else begin
        pop(got);
        check(got == VEC[v][4:0], "R5 FIFO order", got, VEC[v][4:0]);
      end
    end
    idle(4);
    check(out_ready == 1'b0, "R5 drained", out_ready, 0);

    // R10 output enable
    push(5'd7);
    idle(2);
    oe = 1'b0; idle(1);
    check(q_hiz == 1'b1, "R10 q_hiz when oe low", q_hiz, 1);
    check(q_data == 5'd0, "R10 q_data zero when oe low", q_data, 0);
    check(out_ready == 1'b1, "R10 out_ready unaffected", out_ready, 1);
    oe = 1'b1; idle(1);
    check(q_data == 5'd7 && q_hiz == 1'b0, "R10 word back after oe", q_data, 7);
    pop(got);
    check(got == 5'd7, "R10 word intact", got, 7);

    // R7 fill to 64
    for (int i = 0; i < 64; i++) push(5'((i * 3) & 31));
    check(in_ready == 1'b0, "R7 in_ready low when full", in_ready, 0);
    @(negedge clk); din = 5'h1F; shift_in = 1'b1; idle(4); shift_in = 1'b0; idle(6);
    check(in_ready == 1'b0, "R7 push while full ignored", in_ready, 0);

    // R8 recovery timing
    got = q_data;
    check(got == 5'd0, "R8 head word", got, 0);
    @(negedge clk); shift_out = 1'b1; idle(4);
    shift_out = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b0, "R8 in_ready still low at read commit", in_ready, 0);
    @(posedge clk); @(negedge clk);
    check(in_ready == 1'b1, "R8 in_ready high one clock later", in_ready, 1);
    for (int i = 1; i < 64; i++) begin
      pop(got);
      check(got == 5'((i * 3) & 31), "R7 drained word", got, (i * 3) & 31);
    end
    idle(6);
    check(out_ready == 1'b0, "R7 no extra word stored while full", out_ready, 0);

    // R11 overlapped push and pop
    push(5'd20);
    idle(2);
    check(q_data == 5'd20, "R11 head before overlap", q_data, 20);
    @(negedge clk); din = 5'd21; shift_in = 1'b1; shift_out = 1'b1;
    idle(4);
    shift_in = 1'b0; shift_out = 1'b0;
    idle(6);
    check(out_ready == 1'b1 && q_data == 5'd21, "R11 new word presented", q_data, 21);
    check(in_ready == 1'b1, "R11 in_ready after overlap", in_ready, 1);
    pop(got);
    idle(4);
    check(out_ready == 1'b0, "R11 occupancy back to zero", out_ready, 0);

    done = 1;
    summary();
  end
endmodule